// File: doc/BRIEF.md
# Quad-Rail Word Codec with Completion Detection

This block moves binary words into and out of a delay-insensitive four-rail code. The word is split into 2-bit groups. Each group travels on four wires, and a valid value drives exactly one of those wires to its active level. Because the code itself shows when a word has arrived, no separate strobe with a matched delay is needed. Between two values the wires fall back to an all-cleared spacer. A new evaluation must not begin until that spacer has been seen.

The encoder side turns a binary word into rails, or into the spacer while its valid input is low. The decoder side takes a rail word and returns the binary value. It also reports, per group and for the whole word, whether each group holds a codeword, whether the word is completely cleared, and whether any group carries an illegal code with more than one active wire. Word-level completion is a plain AND of the per-group results. A parameter chooses the rail polarity: active-low, which suits precharged logic and is the default, or active-high.

Top module: `quad_rail_codec`

## Requirements
- R1: For group g, binary value v (00, 01, 10, 11) on data bits [2g+1:2g] activates rail 4g+v, and only that rail, in the group's four rails [4g+3:4g].
- R2: With INVERT=1 an active rail is 0 and a cleared rail is 1. With INVERT=0 an active rail is 1 and a cleared rail is 0.
- R3: While enc_valid_i is low, every encoder rail sits at the cleared level (the spacer).
- R4: grp_done_o[g] is high exactly when group g of dec_rails_i has one active rail.
- R5: word_valid_o is high exactly when every group has one active rail.
- R6: word_empty_o is high exactly when no rail in the word is active.
- R7: code_err_o is high exactly when some group has two or more active rails, and word_valid_o is then low.
- R8: dec_data_o bits [2g+1:2g] equal the index of the active rail when group g holds a codeword, and 00 otherwise.
- R9: A word in which some groups are cleared and the rest hold codewords raises neither word_valid_o, word_empty_o nor code_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | DATA_W | Binary word to encode |
| enc_valid_i | input | 1 | High: encode the word; low: emit the spacer |
| enc_rails_o | output | 2*DATA_W | Encoded rails, four per group |
| dec_rails_i | input | 2*DATA_W | Rails to decode and check for completion |
| dec_data_o | output | DATA_W | Decoded binary word |
| grp_done_o | output | DATA_W/2 | Per-group codeword present |
| word_valid_o | output | 1 | Every group holds a codeword |
| word_empty_o | output | 1 | Every rail is cleared |
| code_err_o | output | 1 | Some group has more than one active rail |

## Verification
The bench builds two copies. The first uses the default 16-bit word with active-low rails. It covers every group value at every position, spacer emission, encoder-to-decoder round trips, illegal codes and partly filled words. The second is 4 bits wide with active-high rails, so its 8 decoder rails are small enough to check all 256 rail patterns against a model in the bench. That copy reaches every mix of cleared, valid and illegal groups and proves the other polarity.

// File: rtl/quad_rail_codec.sv
module quad_rail_codec #(
  parameter int DATA_W = 16,
  parameter bit INVERT = 1'b1
) (
  input  logic [DATA_W-1:0]   enc_data_i,
  input  logic                enc_valid_i,
  output logic [2*DATA_W-1:0] enc_rails_o,
  input  logic [2*DATA_W-1:0] dec_rails_i,
  output logic [DATA_W-1:0]   dec_data_o,
  output logic [DATA_W/2-1:0] grp_done_o,
  output logic                word_valid_o,
  output logic                word_empty_o,
  output logic                code_err_o
);
  localparam int GROUPS = DATA_W / 2;

  logic [GROUPS-1:0] grp_none;
  logic [GROUPS-1:0] grp_multi;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [3:0] enc_act;
    logic [3:0] dec_act;
    logic [3:0] dec_low_cleared;

    assign enc_act = enc_valid_i ? (4'b0001 << enc_data_i[2*g +: 2]) : 4'b0000;

    if (INVERT) begin : g_neg
      assign enc_rails_o[4*g +: 4] = ~enc_act;
      assign dec_act               = ~dec_rails_i[4*g +: 4];
    end else begin : g_pos
      assign enc_rails_o[4*g +: 4] = enc_act;
      assign dec_act               = dec_rails_i[4*g +: 4];
    end

    assign dec_low_cleared = dec_act & (dec_act - 4'd1);
    assign grp_none[g]     = (dec_act == 4'b0000);
    assign grp_multi[g]    = (dec_low_cleared != 4'b0000);
    assign grp_done_o[g]   = !grp_none[g] && !grp_multi[g];

    assign dec_data_o[2*g +: 2] = grp_done_o[g] ?
                                  {dec_act[3] | dec_act[2], dec_act[3] | dec_act[1]} : 2'b00;
  end

  assign word_valid_o = &grp_done_o;
  assign word_empty_o = &grp_none;
  assign code_err_o   = |grp_multi;
endmodule

module quad_rail_codec_chk #(
  parameter int DATA_W = 16,
  parameter bit INVERT = 1'b1
) (
  input logic [DATA_W-1:0]   enc_data_i,
  input logic                enc_valid_i,
  input logic [2*DATA_W-1:0] enc_rails_o,
  input logic [2*DATA_W-1:0] dec_rails_i,
  input logic [DATA_W-1:0]   dec_data_o,
  input logic [DATA_W/2-1:0] grp_done_o,
  input logic                word_valid_o,
  input logic                word_empty_o,
  input logic                code_err_o
);
  localparam logic [2*DATA_W-1:0] CLEARED = INVERT ? '1 : '0;

  always_comb begin
    p_spacer_r3: assert (enc_valid_i || enc_rails_o == CLEARED);
    p_err_blocks_valid_r7: assert (!(code_err_o && word_valid_o));
    p_valid_not_empty_r5: assert (!(word_valid_o && word_empty_o));
    p_valid_all_groups_r4: assert (!word_valid_o || $countones(grp_done_o) == DATA_W/2);
    p_one_rail_each_r1: assert (!enc_valid_i ||
                                $countones(enc_rails_o ^ CLEARED) == DATA_W/2);
    p_roundtrip_r8: assert (!(enc_valid_i && dec_rails_i == enc_rails_o) ||
                            (word_valid_o && dec_data_o == enc_data_i));
  end
endmodule

bind quad_rail_codec quad_rail_codec_chk #(.DATA_W(DATA_W), .INVERT(INVERT)) u_chk (
  .enc_data_i(enc_data_i), .enc_valid_i(enc_valid_i), .enc_rails_o(enc_rails_o),
  .dec_rails_i(dec_rails_i), .dec_data_o(dec_data_o), .grp_done_o(grp_done_o),
  .word_valid_o(word_valid_o), .word_empty_o(word_empty_o), .code_err_o(code_err_o)
);

// File: tb/tb_quad_rail_codec.sv
module tb_quad_rail_codec;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [15:0] e_data;
  logic        e_valid;
  logic [31:0] e_rails;
  logic [31:0] d_rails;
  logic [15:0] d_data;
  logic [7:0]  d_done;
  logic        d_valid, d_empty, d_err;

  quad_rail_codec #(.DATA_W(16), .INVERT(1'b1)) dut (
    .enc_data_i(e_data), .enc_valid_i(e_valid), .enc_rails_o(e_rails),
    .dec_rails_i(d_rails), .dec_data_o(d_data), .grp_done_o(d_done),
    .word_valid_o(d_valid), .word_empty_o(d_empty), .code_err_o(d_err)
  );

  logic [3:0] s_data;
  logic       s_valid;
  logic [7:0] s_rails;
  logic [7:0] s_drails;
  logic [3:0] s_ddata;
  logic [1:0] s_done;
  logic       s_wvalid, s_empty, s_err;

  quad_rail_codec #(.DATA_W(4), .INVERT(1'b0)) dut_pos (
    .enc_data_i(s_data), .enc_valid_i(s_valid), .enc_rails_o(s_rails),
    .dec_rails_i(s_drails), .dec_data_o(s_ddata), .grp_done_o(s_done),
    .word_valid_o(s_wvalid), .word_empty_o(s_empty), .code_err_o(s_err)
  );

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_enc(input logic [15:0] d);
    logic [31:0] r = '1;
    for (int g = 0; g < 8; g++) r[4*g + d[2*g +: 2]] = 1'b0;
    return r;
  endfunction

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_spacer();
    e_valid = 1'b0; e_data = 16'hA5C3; d_rails = '1;
    settle();
    chk("R3 spacer rails", e_rails, 32'hFFFF_FFFF);
    chk("R6 empty on cleared word", {31'd0, d_empty}, 32'd1);
    chk("R5 no valid on cleared word", {31'd0, d_valid}, 32'd0);
    chk("R4 no group done", {24'd0, d_done}, 32'd0);
  endtask

  task automatic t_encode();
    for (int v = 0; v < 4; v++) begin
      e_valid = 1'b1; e_data = {8{v[1:0]}};
      settle();
      chk("R1 R2 uniform group value", e_rails, model_enc(e_data));
    end
    for (int g = 0; g < 8; g++) begin
      e_data = 16'd3 << (2*g);
      settle();
      chk("R1 single group at 3", e_rails, model_enc(e_data));
    end
    e_data = 16'h1B6E;
    settle();
    chk("R1 mixed word", e_rails, model_enc(16'h1B6E));
  endtask

  task automatic t_roundtrip();
    logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h1234, 16'hC0DE};
    e_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      e_data = pats[i];
      d_rails = model_enc(pats[i]);
      settle();
      chk("R8 decoded word", {16'd0, d_data}, {16'd0, pats[i]});
      chk("R5 valid on full word", {31'd0, d_valid}, 32'd1);
      chk("R4 all groups done", {24'd0, d_done}, 32'h0000_00FF);
    end
  endtask

  task automatic t_illegal();
    d_rails = model_enc(16'h0000);
    d_rails[4*3 + 2] = 1'b0;
    settle();
    chk("R7 error flag", {31'd0, d_err}, 32'd1);
    chk("R7 valid suppressed", {31'd0, d_valid}, 32'd0);
    chk("R4 group 3 not done", {24'd0, d_done}, 32'h0000_00F7);
    chk("R8 bad group decodes 00", {16'd0, d_data}, 32'd0);
  endtask

  task automatic t_partial();
    d_rails = model_enc(16'hFFFF);
    d_rails[31:16] = 16'hFFFF;
    settle();
    chk("R9 partial not valid", {31'd0, d_valid}, 32'd0);
    chk("R9 partial not empty", {31'd0, d_empty}, 32'd0);
    chk("R9 partial no error", {31'd0, d_err}, 32'd0);
    chk("R8 partial decode", {16'd0, d_data}, 32'h0000_00FF);
  endtask

  task automatic t_pos_exhaustive();
    for (int v = 0; v < 16; v++) begin
      s_valid = 1'b1; s_data = v[3:0];
      settle();
      chk("R2 active-high encode", {24'd0, s_rails},
          {24'd0, 4'b0001 << v[3:2], 4'b0001 << v[1:0]});
    end
    s_valid = 1'b0;
    settle();
    chk("R3 active-high spacer", {24'd0, s_rails}, 32'd0);
    for (int p = 0; p < 256; p++) begin
      logic [1:0] done, none, multi;
      logic [3:0] dd;
      s_drails = p[7:0];
      for (int g = 0; g < 2; g++) begin
        logic [3:0] a = p[4*g +: 4];
        none[g]  = ($countones(a) == 0);
        multi[g] = ($countones(a) > 1);
        done[g]  = ($countones(a) == 1);
        dd[2*g +: 2] = done[g] ? (a[1] ? 2'd1 : a[2] ? 2'd2 : a[3] ? 2'd3 : 2'd0) : 2'd0;
      end
      settle();
      chk("R4 R5 R6 R7 R8 flags and data",
          {21'd0, s_done, s_wvalid, s_empty, s_err, s_ddata},
          {21'd0, done, &done, &none, |multi, dd});
    end
  endtask

  initial begin
    e_data = '0; e_valid = 1'b0; d_rails = '1;
    s_data = '0; s_valid = 1'b0; s_drails = '0;
    t_spacer();
    t_encode();
    t_roundtrip();
    t_illegal();
    t_partial();
    t_pos_exhaustive();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule